// File: doc/BRIEF.md
# Burst-Capable Local Bus Cycle Sequencer

This block sits on the processor side of a 32-bit local bus and turns internal transfer requests into external bus cycles. A request carries a 3-bit cycle type, a word address, one word of write data and a burst flag. When the sequencer accepts a request, it pulses an active-low address strobe for one clock. In that same clock it presents the address and the three cycle-definition outputs (memory/IO, data/control, write/read). It then waits for the system to answer with either an active-low single-transfer ready or an active-low burst ready.

On write-type cycles the sequencer drives the data word and one even-parity bit per byte lane. It starts doing so in the second clock of the cycle. On read-type cycles it captures the data word on every ready clock. It also compares the returned lane parity and flags any mismatch. A mismatch only raises a status flag and never changes the transfer. A burst read moves up to four words at consecutive word addresses. A single-transfer ready that arrives in any clock ends the burst at once. A pending output tells the rest of the chip whenever a request is waiting.

Top module: `lbus_seq`

## Requirements
- R1: For each accepted request, `ads_n` is low for exactly one clock, the clock after acceptance. In that clock `addr_o` equals the request word address. The cycle-definition outputs stay unchanged from that clock until the cycle ends.
- R2: `{mio_o, dc_o, wr_o}` equals the request type. The codes are: 000 interrupt acknowledge, 001 halt/special, 010 I/O read, 011 I/O write, 100 code read, 101 reserved, 110 memory read and 111 memory write. Bit 0 (`wr_o`) set means a write.
- R3: `rdy_n` and `brdy_n` have no effect while the bus is idle or during the strobe clock. No capture, no `cyc_done` and no strobe follow from them there.
- R4: In a read cycle, every clock from the second one on in which `rdy_n` or `brdy_n` is low captures `data_i`. It appears on `rd_data` with `rd_valid` high in the next clock.
- R5: When `rdy_n` and `brdy_n` are both low in the same clock, that transfer is the last one. `cyc_done` pulses in the next clock.
- R6: A burst applies only to code reads (100) and memory reads (110) with the burst flag set. It performs up to 4 transfers and advances `addr_o` by one word after each `brdy_n` transfer. It ends after the fourth.
- R7: Any cycle that is not a burst ends on its first ready of either kind.
- R8: `data_oe` is high exactly from the second clock of a write cycle through its final ready clock. `data_o` then carries the request data.
- R9: While `data_oe` is high, `par_o[i]` is the XOR of `data_o[8i+7:8i]`, so that each lane plus its parity bit has even weight. When `data_oe` is low, `par_o` is zero.
- R10: `rd_perr` is high alongside `rd_valid` exactly when some `par_i[i]` differs from the XOR of the captured lane `i`. A mismatch does not change the data or the transfer count.
- R11: `pend_o` is high whenever `req_valid` is high, whether or not a cycle is on the bus.
- R12: A request presented while the final ready is sampled is accepted at that edge. Its strobe appears in the very next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Internal request present |
| req_type | input | 3 | Cycle type {memory/IO, data/control, write/read} |
| req_addr | input | ADDR_W-2 | Request word address |
| req_wdata | input | DATA_W | Write data |
| req_burst | input | 1 | Burst wanted (read types only) |
| req_ready | output | 1 | Request accepted at this edge |
| pend_o | output | 1 | Internal request pending |
| ads_n | output | 1 | Address strobe, active low |
| mio_o | output | 1 | Memory (1) or I/O (0) |
| dc_o | output | 1 | Data (1) or control (0) |
| wr_o | output | 1 | Write (1) or read (0) |
| addr_o | output | ADDR_W-2 | Bus word address |
| data_o | output | DATA_W | Write data to bus |
| data_oe | output | 1 | Data and parity drive enable |
| par_o | output | DATA_W/8 | Write lane parity |
| data_i | input | DATA_W | Read data from bus |
| par_i | input | DATA_W/8 | Read lane parity |
| rdy_n | input | 1 | Single-transfer ready, active low |
| brdy_n | input | 1 | Burst ready, active low |
| rd_valid | output | 1 | Captured read word valid |
| rd_data | output | DATA_W | Captured read word |
| rd_perr | output | 1 | Parity mismatch on captured word |
| cyc_done | output | 1 | Cycle ended in previous clock |

## Verification
The bench uses the default build: 32-bit address and data, four byte lanes and a four-beat burst limit. That size is small enough to sweep every one of the eight type codes. Each code is run with and without the burst flag, with zero or one wait state, and with an early abort at each beat position as well as no abort. Parity faults rotate across lanes and beats, and ready noise is injected in strobe clocks and idle clocks. The sweep therefore reaches every burst length from one to four, every lane of the parity logic, and back-to-back starts after each kind of termination.

// File: rtl/lbus_pkg.sv
package lbus_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ADDR = 2'd1,
        ST_XFER = 2'd2
    } seq_state_e;

    localparam logic [2:0] CT_CODE_RD = 3'b100;
    localparam logic [2:0] CT_MEM_RD  = 3'b110;

    function automatic logic burst_capable(input logic [2:0] ctype);
        return (ctype == CT_CODE_RD) || (ctype == CT_MEM_RD);
    endfunction

endpackage

// File: rtl/lbus_lane_parity.sv
module lbus_lane_parity #(
    parameter int DATA_W = 32,
    localparam int LANES = DATA_W / 8
) (
    input  logic [DATA_W-1:0] word_i,
    output logic [LANES-1:0]  par_o
);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign par_o[g] = ^word_i[8*g +: 8];
    end

endmodule

// File: rtl/lbus_seq_core.sv
module lbus_seq_core
    import lbus_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int DATA_W    = 32,
    parameter int MAX_BEATS = 4,
    localparam int OFS_W    = $clog2(DATA_W / 8),
    localparam int WORD_W   = ADDR_W - OFS_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [2:0]        req_type,
    input  logic [WORD_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              req_burst,
    output logic              req_ready,
    output logic              ads_n,
    output logic [2:0]        cyc_type,
    output logic [WORD_W-1:0] word_o,
    output logic [DATA_W-1:0] wdata_o,
    output logic              data_oe,
    input  logic [DATA_W-1:0] data_i,
    input  logic              par_bad_i,
    input  logic              rdy_n,
    input  logic              brdy_n,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_perr,
    output logic              cyc_done
);

    localparam int BEAT_W = (MAX_BEATS > 1) ? $clog2(MAX_BEATS) : 1;
    localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(MAX_BEATS - 1);

    typedef struct packed {
        seq_state_e        st;
        logic [2:0]        ctype;
        logic [WORD_W-1:0] word;
        logic [DATA_W-1:0] wdata;
        logic              burst;
        logic [BEAT_W-1:0] beat;
        logic              rvalid;
        logic [DATA_W-1:0] rdata;
        logic              perr;
        logic              done;
    } seq_regs_t;

    seq_regs_t r_q, r_d;
    logic      accept_c;
    logic      term_c;
    logic      xfer_c;

    always_comb begin
        r_d        = r_q;
        r_d.rvalid = 1'b0;
        r_d.perr   = 1'b0;
        r_d.done   = 1'b0;
        accept_c   = 1'b0;
        term_c     = 1'b0;
        xfer_c     = 1'b0;

        case (r_q.st)
            ST_IDLE: accept_c = req_valid;
            ST_ADDR: r_d.st = ST_XFER;
            ST_XFER: begin
                xfer_c = !rdy_n || !brdy_n;
                if (xfer_c) begin
                    if (!r_q.ctype[0]) begin
                        r_d.rvalid = 1'b1;
                        r_d.rdata  = data_i;
                        r_d.perr   = par_bad_i;
                    end
                    if (!rdy_n || !r_q.burst || (r_q.beat == LAST_BEAT)) begin
                        term_c   = 1'b1;
                        r_d.done = 1'b1;
                        r_d.st   = ST_IDLE;
                        accept_c = req_valid;
                    end else begin
                        r_d.beat = r_q.beat + 1'b1;
                        r_d.word = r_q.word + 1'b1;
                    end
                end
            end
            default: r_d.st = ST_IDLE;
        endcase

        if (accept_c) begin
            r_d.st    = ST_ADDR;
            r_d.ctype = req_type;
            r_d.word  = req_addr;
            r_d.wdata = req_wdata;
            r_d.burst = req_burst && burst_capable(req_type);
            r_d.beat  = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, default: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign req_ready = (r_q.st == ST_IDLE) || term_c;
    assign ads_n     = (r_q.st != ST_ADDR);
    assign cyc_type  = r_q.ctype;
    assign word_o    = r_q.word;
    assign data_oe   = (r_q.st == ST_XFER) && r_q.ctype[0];
    assign wdata_o   = data_oe ? r_q.wdata : '0;
    assign rd_valid  = r_q.rvalid;
    assign rd_data   = r_q.rdata;
    assign rd_perr   = r_q.perr;
    assign cyc_done  = r_q.done;

endmodule

// File: rtl/lbus_seq.sv
module lbus_seq #(
    parameter int ADDR_W    = 32,
    parameter int DATA_W    = 32,
    parameter int MAX_BEATS = 4
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 req_valid,
    input  logic [2:0]                           req_type,
    input  logic [ADDR_W-1:$clog2(DATA_W/8)]     req_addr,
    input  logic [DATA_W-1:0]                    req_wdata,
    input  logic                                 req_burst,
    output logic                                 req_ready,
    output logic                                 pend_o,
    output logic                                 ads_n,
    output logic                                 mio_o,
    output logic                                 dc_o,
    output logic                                 wr_o,
    output logic [ADDR_W-1:$clog2(DATA_W/8)]     addr_o,
    output logic [DATA_W-1:0]                    data_o,
    output logic                                 data_oe,
    output logic [DATA_W/8-1:0]                  par_o,
    input  logic [DATA_W-1:0]                    data_i,
    input  logic [DATA_W/8-1:0]                  par_i,
    input  logic                                 rdy_n,
    input  logic                                 brdy_n,
    output logic                                 rd_valid,
    output logic [DATA_W-1:0]                    rd_data,
    output logic                                 rd_perr,
    output logic                                 cyc_done
);

    localparam int LANES = DATA_W / 8;

    logic [2:0]       cyc_type;
    logic [LANES-1:0] wpar;
    logic [LANES-1:0] rpar;
    logic             par_bad;

    lbus_seq_core #(
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W),
        .MAX_BEATS(MAX_BEATS)
    ) core_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_valid(req_valid),
        .req_type (req_type),
        .req_addr (req_addr),
        .req_wdata(req_wdata),
        .req_burst(req_burst),
        .req_ready(req_ready),
        .ads_n    (ads_n),
        .cyc_type (cyc_type),
        .word_o   (addr_o),
        .wdata_o  (data_o),
        .data_oe  (data_oe),
        .data_i   (data_i),
        .par_bad_i(par_bad),
        .rdy_n    (rdy_n),
        .brdy_n   (brdy_n),
        .rd_valid (rd_valid),
        .rd_data  (rd_data),
        .rd_perr  (rd_perr),
        .cyc_done (cyc_done)
    );

    lbus_lane_parity #(.DATA_W(DATA_W)) wpar_i (
        .word_i(data_o),
        .par_o (wpar)
    );

    lbus_lane_parity #(.DATA_W(DATA_W)) rpar_i (
        .word_i(data_i),
        .par_o (rpar)
    );

    assign par_bad = |(rpar ^ par_i);
    assign par_o   = data_oe ? wpar : '0;
    assign mio_o   = cyc_type[2];
    assign dc_o    = cyc_type[1];
    assign wr_o    = cyc_type[0];
    assign pend_o  = req_valid;

endmodule

// File: rtl/lbus_seq_chk.sv
module lbus_seq_chk #(
    parameter int DATA_W = 32,
    localparam int LANES = DATA_W / 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              pend_o,
    input logic              ads_n,
    input logic              mio_o,
    input logic              dc_o,
    input logic              wr_o,
    input logic [DATA_W-1:0] data_o,
    input logic              data_oe,
    input logic [LANES-1:0]  par_o,
    input logic              rdy_n,
    input logic              brdy_n,
    input logic              rd_valid
);

    // R1
    ads_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ads_n |=> ads_n);

    // R1
    def_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ads_n |=> $stable({mio_o, dc_o, wr_o}));

    // R3
    strobe_noready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ads_n |=> !rd_valid);

    // R4
    capture_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(!rdy_n || !brdy_n));

    // R8
    oe_late_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ads_n |-> !data_oe);

    // R8
    oe_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        data_oe |-> wr_o);

    for (genvar g = 0; g < LANES; g++) begin : g_par
        // R9
        par_even_chk: assert property (@(posedge clk) disable iff (!rst_n)
            data_oe |-> (par_o[g] == ^data_o[8*g +: 8]));
    end

    // R11
    pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> pend_o);

endmodule

bind lbus_seq lbus_seq_chk #(.DATA_W(DATA_W)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_valid(req_valid),
    .pend_o   (pend_o),
    .ads_n    (ads_n),
    .mio_o    (mio_o),
    .dc_o     (dc_o),
    .wr_o     (wr_o),
    .data_o   (data_o),
    .data_oe  (data_oe),
    .par_o    (par_o),
    .rdy_n    (rdy_n),
    .brdy_n   (brdy_n),
    .rd_valid (rd_valid)
);

// File: tb/lbus_seq_tb_top.sv
module lbus_seq_tb_top;

    localparam int NRUN = 160;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid, req_burst, req_ready, pend_o;
    logic [2:0]  req_type;
    logic [31:2] req_addr, addr_o;
    logic [31:0] req_wdata, data_o, data_i, rd_data;
    logic        ads_n, mio_o, dc_o, wr_o, data_oe, rdy_n, brdy_n;
    logic        rd_valid, rd_perr, cyc_done;
    logic [3:0]  par_o, par_i;

    int checks = 0;
    int errors = 0;
    int cyc_cnt = 0;

    always #5 clk = ~clk;

    lbus_seq dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_type(req_type),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_burst(req_burst),
        .req_ready(req_ready), .pend_o(pend_o), .ads_n(ads_n), .mio_o(mio_o),
        .dc_o(dc_o), .wr_o(wr_o), .addr_o(addr_o), .data_o(data_o),
        .data_oe(data_oe), .par_o(par_o), .data_i(data_i), .par_i(par_i),
        .rdy_n(rdy_n), .brdy_n(brdy_n), .rd_valid(rd_valid), .rd_data(rd_data),
        .rd_perr(rd_perr), .cyc_done(cyc_done)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] mem_word(input logic [31:2] w);
        return ({2'b00, w} * 32'h9E3779B1) ^ 32'h5A5A0F0F;
    endfunction

    function automatic logic [3:0] even_par(input logic [31:0] d);
        logic [3:0] p;
        for (int i = 0; i < 4; i++) p[i] = ^d[8*i +: 8];
        return p;
    endfunction

    function automatic logic [31:2] base_of(input int idx);
        return 30'(32'h400 + idx * 16);
    endfunction

    function automatic logic [31:0] wdata_of(input int idx);
        return (32'(idx) * 32'h01010101) ^ 32'hA5C3_3C5A;
    endfunction

    task automatic present(input int idx);
        req_valid = 1'b1;
        req_type  = 3'(idx % 8);
        req_burst = ((idx / 8) % 2) == 1;
        req_addr  = base_of(idx);
        req_wdata = wdata_of(idx);
    endtask

    // one bus cycle; starts and ends on a negedge
    task automatic run_cycle(input int idx, input bit armed, input bit chain);
        logic [2:0]  ty   = 3'(idx % 8);
        bit          bst  = ((idx / 8) % 2) == 1;
        int          wt   = (idx / 16) % 2;
        int          ab   = (idx / 32) % 5 - 1;
        bit          wr   = ty[0];
        bit          beff = bst && (ty == 3'b100 || ty == 3'b110);
        int          exp_beats = beff ? ((ab >= 0) ? ab + 1 : 4) : 1;
        int          beat = 0;
        int          wleft = wt;
        int          rcount = 0;
        bit          prev_rd = 1'b0;
        logic [31:0] prev_d = '0;
        bit          prev_e = 1'b0;
        bit          fin = 1'b0;
        bit          corrupt;
        bit          last;

        if (!armed) begin
            chk(pend_o == 1'b0, "R11 idle pend", 64'(pend_o), 0);
            present(idx);
            #1;
            chk(pend_o == 1'b1, "R11 pend", 64'(pend_o), 1);
            chk(req_ready == 1'b1, "R12 idle ready", 64'(req_ready), 1);
            @(negedge clk);
        end
        // strobe clock
        chk(ads_n == 1'b0, armed ? "R12 strobe" : "R1 strobe", 64'(ads_n), 0);
        chk(addr_o == base_of(idx), "R1 addr", 64'(addr_o), 64'(base_of(idx)));
        chk({mio_o, dc_o, wr_o} == ty, "R2 type", 64'({mio_o, dc_o, wr_o}), 64'(ty));
        chk(data_oe == 1'b0, "R8 strobe oe", 64'(data_oe), 0);
        req_valid = 1'b0;
        rdy_n  = (wt == 1) ? 1'b0 : 1'b1;   // R3 noise in strobe clock
        brdy_n = (wt == 1) ? 1'b0 : 1'b1;

        while (!fin) begin
            @(negedge clk);
            chk(rd_valid == prev_rd, "R3/R4 rd_valid", 64'(rd_valid), 64'(prev_rd));
            if (prev_rd) begin
                rcount++;
                chk(rd_data == prev_d, "R4 data", 64'(rd_data), 64'(prev_d));
                chk(rd_perr == prev_e, "R10 perr", 64'(rd_perr), 64'(prev_e));
            end
            chk(ads_n == 1'b1, "R1 single strobe", 64'(ads_n), 1);
            chk(cyc_done == 1'b0, "R3 done early", 64'(cyc_done), 0);
            chk({mio_o, dc_o, wr_o} == ty, "R1 hold type", 64'({mio_o, dc_o, wr_o}), 64'(ty));
            chk(data_oe == wr, "R8 oe", 64'(data_oe), 64'(wr));
            if (wr) begin
                chk(data_o == wdata_of(idx), "R8 data", 64'(data_o), 64'(wdata_of(idx)));
                chk(par_o == even_par(wdata_of(idx)), "R9 parity",
                    64'(par_o), 64'(even_par(wdata_of(idx))));
            end else begin
                chk(par_o == 4'h0, "R9 parity idle", 64'(par_o), 0);
            end
            chk(addr_o == base_of(idx) + 30'(beat), "R6 addr",
                64'(addr_o), 64'(base_of(idx) + 30'(beat)));
            if (wleft > 0) begin
                wleft--;
                rdy_n = 1'b1; brdy_n = 1'b1;
                prev_rd = 1'b0;
            end else begin
                corrupt = ((idx + beat) % 3) == 0;
                data_i  = mem_word(base_of(idx) + 30'(beat));
                par_i   = even_par(data_i) ^ (corrupt ? 4'(1 << (beat % 4)) : 4'h0);
                if (ab == beat) begin
                    rdy_n = 1'b0; brdy_n = 1'b0;       // R5 abort
                end else if (!beff && (idx % 2 == 1)) begin
                    rdy_n = 1'b0; brdy_n = 1'b1;
                end else begin
                    rdy_n = 1'b1; brdy_n = 1'b0;
                end
                prev_rd = !wr;
                prev_d  = data_i;
                prev_e  = corrupt;
                last = (ab == beat) || !beff || (beat == 3);
                if (last) begin
                    fin = 1'b1;
                    if (chain) present(idx + 1);
                end else begin
                    beat++;
                    wleft = wt;
                end
            end
        end
        @(negedge clk);
        rdy_n = 1'b1; brdy_n = 1'b1;
        chk(rd_valid == prev_rd, "R4 last rd_valid", 64'(rd_valid), 64'(prev_rd));
        if (prev_rd) begin
            rcount++;
            chk(rd_data == prev_d, "R4 last data", 64'(rd_data), 64'(prev_d));
            chk(rd_perr == prev_e, "R10 last perr", 64'(rd_perr), 64'(prev_e));
        end
        chk(cyc_done == 1'b1, (ab >= 0 && beff) ? "R5 done" : "R7 done", 64'(cyc_done), 1);
        chk(rcount == (wr ? 0 : exp_beats), "R6 beat count",
            64'(rcount), 64'(wr ? 0 : exp_beats));
        if (!chain) begin
            chk(ads_n == 1'b1, "R7 idle after end", 64'(ads_n), 1);
            chk(data_oe == 1'b0, "R8 oe after end", 64'(data_oe), 0);
        end
    endtask

    always @(posedge clk) begin
        cyc_cnt++;
        if (cyc_cnt > 150000) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=<150000", cyc_cnt);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        bit armed;
        rst_n = 1'b0;
        req_valid = 1'b0; req_type = '0; req_addr = '0; req_wdata = '0; req_burst = 1'b0;
        data_i = '0; par_i = '0; rdy_n = 1'b1; brdy_n = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // reset state
        chk(ads_n == 1'b1, "R1 reset strobe", 64'(ads_n), 1);
        chk(data_oe == 1'b0, "R8 reset oe", 64'(data_oe), 0);
        chk(rd_valid == 1'b0, "R4 reset rd_valid", 64'(rd_valid), 0);
        chk(req_ready == 1'b1, "R12 reset ready", 64'(req_ready), 1);
        chk(pend_o == 1'b0, "R11 reset pend", 64'(pend_o), 0);
        // R3: readies while idle
        rdy_n = 1'b0; brdy_n = 1'b0;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            chk(ads_n == 1'b1 && rd_valid == 1'b0 && cyc_done == 1'b0,
                "R3 idle ready", 64'({ads_n, rd_valid, cyc_done}), 64'(3'b100));
        end
        rdy_n = 1'b1; brdy_n = 1'b1;
        @(negedge clk);

        armed = 1'b0;
        for (int idx = 0; idx < NRUN; idx++) begin
            bit ch = (idx % 3 == 1) && (idx < NRUN - 1);
            run_cycle(idx, armed, ch);
            armed = ch;
            if (!ch) @(negedge clk);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule